// File: doc/BRIEF.md
# Escaped Serial Frame Encoder

This block builds a byte-stuffed response frame for a daisy-chained I/O bus from a payload that sits in a small RAM. A single start pulse, together with a payload length, launches one frame. The block then reads the payload through a one-cycle-latency read port and presents the frame as a byte stream with a valid/ready handshake. A UART transmitter or a receive FIFO can take that stream directly.

The frame is built in this order. A fixed sync byte comes first, then a node address and a length byte that carries the payload count plus one. The payload follows, with its two reserved values replaced by two-byte escape sequences. A checksum closes the frame. The checksum sums the node byte, the length byte and every byte sent in the payload section, escape bytes included, and transmits that sum minus one. Payload reads are prefetched into a small queue, so the stream can carry one byte per cycle while the consumer keeps ready high.

Top module: `esc_frame_encoder`

## Requirements
- R1: While reset (synchronous, active high) is asserted and in the cycle after its release, out_valid_o, busy_o and rd_en_o are all 0.
- R2: An accepted frame begins with three bytes in this order: 0xE0 (sync), 0x00 (node), and then the payload length plus one, taken modulo 256.
- R3: A payload byte that is neither 0xE0 nor 0xD0 is sent unchanged, and payload bytes leave in address order.
- R4: A payload byte of 0xE0 is sent as the two bytes 0xD0 then 0xDF.
- R5: A payload byte of 0xD0 is sent as the two bytes 0xD0 then 0xCF.
- R6: The last byte of a frame is (0x00 + length byte + the sum of all bytes sent in the payload section) minus one, low 8 bits. It is sent as is, even when it equals 0xE0 or 0xD0.
- R7: A zero-length payload gives exactly the four bytes 0xE0, 0x00, 0x01, 0x00 and issues no RAM reads.
- R8: A byte moves only in a cycle where out_valid_o and out_ready_i are both high. While valid is high and ready is low, valid stays high and the data does not change.
- R9: busy_o rises in the cycle after an accepted start and falls in the cycle after the checksum byte moves. A start pulse while busy_o is high is ignored and leaves the running frame unchanged. out_valid_o is 0 whenever busy_o is 0.
- R10: With out_ready_i held high, a frame of B output bytes keeps busy_o high for exactly B cycles, one byte per cycle with no gaps, escapes included.
- R11: Each frame reads RAM addresses 0 to length-1 once each, in increasing order, and reads only while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame launch pulse, taken only while idle |
| len_i | input | ADDR_W | Payload byte count, sampled with start_i |
| rd_en_o | output | 1 | Payload RAM read strobe |
| rd_addr_o | output | ADDR_W | Payload RAM read address |
| rd_data_i | input | 8 | Payload RAM read data, valid the cycle after rd_en_o |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_ready_i | input | 1 | Consumer ready |
| busy_o | output | 1 | A frame is in progress |

## Verification
A wrong internal state shows at the ports within one byte of where it goes wrong. A miscounted payload index either cuts off or stretches the data section, so the next byte seen is a checksum or payload byte where the other was due. A broken escape step leaves 0xD0 without its partner byte. An accumulator fault never touches the payload bytes and surfaces only in the final byte of the frame. A prefetch queue that runs dry or is refilled out of order shows either as a gap in the always-ready stream or as a payload byte from the wrong address. The reference model compares every transferred byte against its own expected queue in the cycle the byte moves, and it also tracks busy_o, the read addresses and the stall stability on every clock.

// File: rtl/enc_pkg.sv
package enc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_NODE,
    ST_LEN,
    ST_DATA,
    ST_ESC2,
    ST_CSUM
  } enc_state_e;

  localparam logic [7:0] SYNC_CODE = 8'hE0;
  localparam logic [7:0] ESC_LEAD  = 8'hD0;
  localparam logic [7:0] ESC_SYNC  = 8'hDF;
  localparam logic [7:0] ESC_SELF  = 8'hCF;

  // a payload value that collides with framing must be escaped
  function automatic logic is_reserved(input logic [7:0] b);
    return (b == SYNC_CODE) || (b == ESC_LEAD);
  endfunction

  // second byte of an escape pair
  function automatic logic [7:0] esc_tail(input logic [7:0] b);
    return (b == SYNC_CODE) ? ESC_SYNC : ESC_SELF;
  endfunction

  // byte sent in the length slot
  function automatic logic [7:0] len_field(input logic [7:0] n);
    return n + 8'd1;
  endfunction

  // value sent in the checksum slot
  function automatic logic [7:0] csum_out(input logic [7:0] acc);
    return acc - 8'd1;
  endfunction

endpackage

// File: rtl/enc_prefetch.sv
module enc_prefetch #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 2,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [ADDR_W-1:0] len,
  input  logic              pop,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              head_valid,
  output logic [7:0]        head_data,
  output logic [CNT_W-1:0]  fill
);

  localparam logic [CNT_W:0] DEPTH_V = (CNT_W + 1)'(DEPTH);

  logic [ADDR_W:0]   issued;
  logic              inflight;
  logic [7:0]        slot [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr, wptr_nx, rptr_nx;
  logic [CNT_W-1:0]  cnt;
  logic              pop_ok;
  logic [CNT_W:0]    claimed, room;

  assign head_valid = (cnt != '0);
  assign head_data  = slot[rptr];
  assign fill       = cnt;
  assign pop_ok     = pop && head_valid;

  // entries stored plus the one in flight must stay within the queue
  assign claimed = {1'b0, cnt} + {{CNT_W{1'b0}}, inflight};
  assign room    = DEPTH_V + {{CNT_W{1'b0}}, pop_ok};
  assign rd_en   = en && !clr && (issued < {1'b0, len}) && (claimed < room);
  assign rd_addr = issued[ADDR_W-1:0];

  generate
    if (DEPTH > 1 && (DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wptr_nx = wptr + PTR_W'(1);
      assign rptr_nx = rptr + PTR_W'(1);
    end else if (DEPTH == 1) begin : g_single
      assign wptr_nx = '0;
      assign rptr_nx = '0;
    end else begin : g_wrap
      assign wptr_nx = (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + PTR_W'(1);
      assign rptr_nx = (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + PTR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      issued   <= '0;
      inflight <= 1'b0;
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
    end else begin
      inflight <= rd_en;
      if (rd_en) issued <= issued + (ADDR_W + 1)'(1);
      if (inflight) wptr <= wptr_nx;
      if (pop_ok) rptr <= rptr_nx;
      if (inflight && !pop_ok)      cnt <= cnt + CNT_W'(1);
      else if (!inflight && pop_ok) cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (inflight && wptr == PTR_W'(i)) slot[i] <= rd_data;
    end
  end

endmodule

// File: rtl/enc_csum.sv
module enc_csum (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       add,
  input  logic [7:0] add_val,
  output logic [7:0] acc
);

  always_ff @(posedge clk) begin
    if (rst)       acc <= 8'h00;
    else if (load) acc <= load_val;
    else if (add)  acc <= acc + add_val;
  end

endmodule

// File: rtl/enc_ctrl.sv
module enc_ctrl
  import enc_pkg::*;
#(
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] NODE_ID = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] len_i,
  input  logic              head_valid,
  input  logic [7:0]        head_data,
  input  logic              out_ready,
  input  logic [7:0]        acc,
  output enc_state_e        state,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              pop,
  output logic              frame_start,
  output logic [ADDR_W-1:0] len_q,
  output logic              acc_load,
  output logic [7:0]        acc_load_val,
  output logic              acc_add,
  output logic [7:0]        acc_add_val,
  output logic              esc_lead_fire,
  output logic              csum_fire
);

  enc_state_e        state_nx;
  logic [ADDR_W-1:0] sent_cnt;
  logic              fire, last_item, head_rsv;

  assign frame_start = start_i && (state == ST_IDLE);
  assign fire        = out_valid && out_ready;
  assign head_rsv    = is_reserved(head_data);
  assign last_item   = (sent_cnt == len_q - ADDR_W'(1));

  always_comb begin
    out_valid = 1'b0;
    out_data  = 8'h00;
    unique case (state)
      ST_SYNC: begin out_valid = 1'b1;       out_data = SYNC_CODE; end
      ST_NODE: begin out_valid = 1'b1;       out_data = NODE_ID; end
      ST_LEN:  begin out_valid = 1'b1;       out_data = len_field(8'(len_q)); end
      ST_DATA: begin out_valid = head_valid; out_data = head_rsv ? ESC_LEAD : head_data; end
      ST_ESC2: begin out_valid = 1'b1;       out_data = esc_tail(head_data); end
      ST_CSUM: begin out_valid = 1'b1;       out_data = csum_out(acc); end
      default: begin out_valid = 1'b0;       out_data = 8'h00; end
    endcase
  end

  assign pop           = fire && ((state == ST_DATA && !head_rsv) || state == ST_ESC2);
  assign esc_lead_fire = fire && (state == ST_DATA) && head_rsv;
  assign csum_fire     = fire && (state == ST_CSUM);
  assign acc_load      = fire && (state == ST_LEN);
  assign acc_load_val  = NODE_ID + len_field(8'(len_q));
  assign acc_add       = fire && (state == ST_DATA || state == ST_ESC2);
  assign acc_add_val   = out_data;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (frame_start) state_nx = ST_SYNC;
      ST_SYNC: if (fire) state_nx = ST_NODE;
      ST_NODE: if (fire) state_nx = ST_LEN;
      ST_LEN:  if (fire) state_nx = (len_q == '0) ? ST_CSUM : ST_DATA;
      ST_DATA: if (fire) begin
                 if (head_rsv)       state_nx = ST_ESC2;
                 else if (last_item) state_nx = ST_CSUM;
               end
      ST_ESC2: if (fire) state_nx = last_item ? ST_CSUM : ST_DATA;
      ST_CSUM: if (fire) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      len_q    <= '0;
      sent_cnt <= '0;
    end else begin
      state <= state_nx;
      if (frame_start) begin
        len_q    <= len_i;
        sent_cnt <= '0;
      end else if (pop) begin
        sent_cnt <= sent_cnt + ADDR_W'(1);
      end
    end
  end

endmodule

// File: rtl/esc_frame_encoder.sv
module esc_frame_encoder
  import enc_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         PF_DEPTH = 2,
  parameter logic [7:0] NODE_ID  = 8'h00,
  localparam int        PF_CNT_W = $clog2(PF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] len_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              out_valid_o,
  output logic [7:0]        out_data_o,
  input  logic              out_ready_i,
  output logic              busy_o
);

  enc_state_e          state;
  logic                head_valid, pop, frame_start;
  logic [7:0]          head_data, acc;
  logic [ADDR_W-1:0]   len_q;
  logic                acc_load, acc_add;
  logic [7:0]          acc_load_val, acc_add_val;
  logic                esc_lead_fire, csum_fire;
  logic [PF_CNT_W-1:0] pf_cnt;

  assign busy_o = (state != ST_IDLE);

  enc_ctrl #(.ADDR_W(ADDR_W), .NODE_ID(NODE_ID)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .len_i         (len_i),
    .head_valid    (head_valid),
    .head_data     (head_data),
    .out_ready     (out_ready_i),
    .acc           (acc),
    .state         (state),
    .out_valid     (out_valid_o),
    .out_data      (out_data_o),
    .pop           (pop),
    .frame_start   (frame_start),
    .len_q         (len_q),
    .acc_load      (acc_load),
    .acc_load_val  (acc_load_val),
    .acc_add       (acc_add),
    .acc_add_val   (acc_add_val),
    .esc_lead_fire (esc_lead_fire),
    .csum_fire     (csum_fire)
  );

  enc_prefetch #(.ADDR_W(ADDR_W), .DEPTH(PF_DEPTH)) u_pf (
    .clk        (clk),
    .rst        (rst),
    .clr        (frame_start),
    .en         (busy_o),
    .len        (len_q),
    .pop        (pop),
    .rd_en      (rd_en_o),
    .rd_addr    (rd_addr_o),
    .rd_data    (rd_data_i),
    .head_valid (head_valid),
    .head_data  (head_data),
    .fill       (pf_cnt)
  );

  enc_csum u_csum (
    .clk      (clk),
    .rst      (rst),
    .load     (acc_load),
    .load_val (acc_load_val),
    .add      (acc_add),
    .add_val  (acc_add_val),
    .acc      (acc)
  );

endmodule

// File: rtl/enc_frame_chk.sv
module enc_frame_chk #(
  parameter int DEPTH = 2,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             busy_o,
  input logic             out_valid_o,
  input logic [7:0]       out_data_o,
  input logic             out_ready_i,
  input logic             rd_en_o,
  input logic [CNT_W-1:0] pf_cnt,
  input logic             esc_lead_fire,
  input logic             csum_fire
);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  // R2
  sync_first_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (out_valid_o && out_data_o == 8'hE0));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !out_valid_o);

  // R9
  csum_ends_chk: assert property (@(posedge clk) disable iff (rst)
    csum_fire |=> !busy_o);

  // R4
  esc_pair_chk: assert property (@(posedge clk) disable iff (rst)
    esc_lead_fire |=> (out_valid_o && (out_data_o == 8'hDF || out_data_o == 8'hCF)));

  // R11
  read_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en_o |-> busy_o);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    int'(pf_cnt) <= DEPTH);

endmodule

bind esc_frame_encoder enc_frame_chk #(.DEPTH(PF_DEPTH), .CNT_W(PF_CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start_i       (start_i),
  .busy_o        (busy_o),
  .out_valid_o   (out_valid_o),
  .out_data_o    (out_data_o),
  .out_ready_i   (out_ready_i),
  .rd_en_o       (rd_en_o),
  .pf_cnt        (pf_cnt),
  .esc_lead_fire (esc_lead_fire),
  .csum_fire     (csum_fire)
);

// File: tb/tb_esc_frame_encoder.sv
`timescale 1ns/1ps
module tb_esc_frame_encoder;

  logic       clk = 0;
  logic       rst = 1;
  logic       start_i = 0;
  logic [7:0] len_i = 0;
  logic       rd_en_o;
  logic [7:0] rd_addr_o;
  logic [7:0] rd_data_i = 0;
  logic       out_valid_o;
  logic [7:0] out_data_o;
  logic       out_ready_i = 0;
  logic       busy_o;

  always #5 clk = ~clk;

  esc_frame_encoder dut (
    .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .out_ready_i(out_ready_i), .busy_o(busy_o)
  );

  logic [7:0] pmem [256];
  always @(posedge clk) if (rd_en_o) rd_data_i <= pmem[rd_addr_o];

  int total = 0;
  int bad = 0;
  int ready_mode = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    case (ready_mode)
      0: out_ready_i <= 1'b1;
      1: out_ready_i <= $urandom_range(0, 1) == 1;
      default: out_ready_i <= $urandom_range(0, 3) == 0;
    endcase
  end

  // reference model state
  byte unsigned exp_q[$];
  string        tag_q[$];
  bit           busy_exp = 0;
  bit           prev_stall = 0;
  byte unsigned prev_data = 0;
  int           exp_rd = 0;
  int           frame_len = 0;
  int           frame_bytes = 0;
  int           busy_cyc = 0;

  task automatic build_frame(input int n);
    int s;
    s = 0;
    exp_q.push_back(8'hE0); tag_q.push_back("R2 sync");
    exp_q.push_back(8'h00); tag_q.push_back("R2 node");
    exp_q.push_back(8'(n + 1)); tag_q.push_back(n == 0 ? "R7 length" : "R2 length");
    s = n + 1;
    for (int k = 0; k < n; k++) begin
      byte unsigned v;
      v = pmem[k];
      if (v == 8'hE0) begin
        exp_q.push_back(8'hD0); tag_q.push_back("R4 lead");
        exp_q.push_back(8'hDF); tag_q.push_back("R4 tail");
        s += 8'hD0 + 8'hDF;
      end else if (v == 8'hD0) begin
        exp_q.push_back(8'hD0); tag_q.push_back("R5 lead");
        exp_q.push_back(8'hCF); tag_q.push_back("R5 tail");
        s += 8'hD0 + 8'hCF;
      end else begin
        exp_q.push_back(v); tag_q.push_back("R3 plain");
        s += v;
      end
    end
    exp_q.push_back(8'(s - 1)); tag_q.push_back(n == 0 ? "R7 checksum" : "R6 checksum");
    frame_bytes = exp_q.size();
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      bit nb;
      nb = busy_exp;
      if (prev_stall)  // R8
        chk(out_valid_o && out_data_o == prev_data, "R8 stall hold", out_data_o, prev_data);
      prev_stall = out_valid_o && !out_ready_i;
      prev_data  = out_data_o;
      chk(busy_o == busy_exp, "R9 busy", busy_o, busy_exp);
      if (!busy_exp && out_valid_o) chk(0, "R9 valid while idle", 1, 0);
      if (rd_en_o) begin  // R11
        chk(busy_o && rd_addr_o == 8'(exp_rd), "R11 read address", rd_addr_o, exp_rd);
        exp_rd++;
      end
      if (busy_o) busy_cyc++;
      if (out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) chk(0, "R9 unexpected byte", out_data_o, 0);
        else begin
          byte unsigned e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_data_o == e, t, out_data_o, e);
          if (exp_q.size() == 0) begin
            nb = 0;
            chk(exp_rd == frame_len, "R11 read count", exp_rd, frame_len);
            if (ready_mode == 0)  // R10
              chk(busy_cyc == frame_bytes, "R10 gapless", busy_cyc, frame_bytes);
          end
        end
      end
      if (start_i && !busy_o) begin
        build_frame(int'(len_i));
        nb = 1;
        exp_rd = 0;
        busy_cyc = 0;
        frame_len = int'(len_i);
      end
      busy_exp = nb;
    end
  end

  task automatic pulse_start(input int n);
    @(posedge clk); #1;
    start_i = 1; len_i = 8'(n);
    @(posedge clk); #1;
    start_i = 0;
  endtask

  task automatic wait_done();
    int g;
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while ((busy_exp || exp_q.size() != 0) && g < 5000);
    chk(exp_q.size() == 0, "R9 frame completion", exp_q.size(), 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);  // R1 during reset
    chk(!out_valid_o && !busy_o && !rd_en_o, "R1 reset outputs", {out_valid_o, busy_o, rd_en_o}, 0);
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    chk(!out_valid_o && !busy_o && !rd_en_o, "R1 after release", {out_valid_o, busy_o, rd_en_o}, 0);

    // R7 empty payload
    ready_mode = 0;
    pulse_start(0);
    wait_done();

    // R2 R3 R10 plain payload
    for (int k = 0; k < 6; k++) pmem[k] = 8'(k + 1);
    pulse_start(6);
    wait_done();

    // R4 R5 R8 mixed escapes under backpressure
    pmem[0] = 8'hE0; pmem[1] = 8'h12; pmem[2] = 8'hD0; pmem[3] = 8'hD0;
    pmem[4] = 8'hE0; pmem[5] = 8'hDF; pmem[6] = 8'hCF; pmem[7] = 8'hE1;
    ready_mode = 1;
    pulse_start(8);
    wait_done();

    // R6 checksum value 0xE0 sent unescaped
    ready_mode = 0;
    pmem[0] = 8'hDF;
    pulse_start(1);
    wait_done();

    // R10 escapes keep full rate
    for (int k = 0; k < 20; k++) pmem[k] = (k % 2 == 0) ? 8'hD0 : 8'hE0;
    pulse_start(20);
    wait_done();

    // R9 start while busy is ignored
    for (int k = 0; k < 8; k++) pmem[k] = 8'(8'h40 + k);
    ready_mode = 2;
    pulse_start(8);
    repeat (3) @(posedge clk);
    pulse_start(3);
    wait_done();

    // long payload, heavy escapes, random ready
    for (int k = 0; k < 255; k++) begin
      int r;
      r = $urandom_range(0, 3);
      pmem[k] = (r == 0) ? 8'hE0 : (r == 1) ? 8'hD0 : 8'($urandom_range(0, 255));
    end
    ready_mode = 1;
    pulse_start(255);
    wait_done();

    // back to back frames at full rate
    ready_mode = 0;
    for (int k = 0; k < 4; k++) pmem[k] = 8'(8'h70 + k);
    pulse_start(4);
    wait_done();
    pulse_start(2);
    wait_done();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule